// File: doc/BRIEF.md
# Cluster Performance Monitor Counter Unit

This block is a register-mapped performance monitor for a shared processor cluster. It holds a parameterised number of 32-bit event counters and one dedicated 64-bit cycle counter. Each event counter has a select register that names one line of an incoming event bus. The counter adds one in every clock cycle where that line is high. A global control word, a counter-enable bitmap and an interrupt-enable bitmap decide which counters run and which wraps raise the interrupt. Software sees which counters wrapped through an overflow register that clears as it is read.

Software uses a single-cycle port. A write takes effect at the next rising clock edge. Read data is combinational from the current address, and a read of the overflow register clears it at that same edge. Word addresses: 0 control, 1 counter enable, 2 interrupt enable, 3 overflow status, 4 cycle counter low half, 5 cycle counter high half, 6 and 7 event availability low and high, 32+i event counter i, 64+i select register of counter i. Any other address reads as zero. In every bitmap, bit i stands for event counter i and bit 31 stands for the cycle counter.

Top module: `pmon_top`

## Requirements
- R1: A control read returns the global enable in bit 0 and zeros in bits [10:1]. Bits [15:11] give the number of event counters. Bits [23:16] give the ID code and bits [31:24] give the implementer code.
- R2: A counter changes only when the global enable and its own enable bit are both 1. Event counter i adds one for each such cycle in which event line sel[i] is high. A select value at or beyond the bus width counts nothing. Select registers read back zero-extended.
- R3: An event counter that increments from 0xFFFFFFFF becomes 0, and overflow bit i is set at that edge.
- R4: The cycle counter adds one on every enabled cycle. It uses enable bit 31, reads as two 32-bit halves, and when it wraps from all ones it becomes 0 and sets overflow bit 31.
- R5: A read of the overflow register returns its bits and clears them at that edge. A wrap in the same cycle as that read leaves its bit set.
- R6: irqOut is high exactly while some overflow bit is set whose interrupt-enable bit is also 1.
- R7: Writing control with bit 1 set zeroes every event counter. Writing control with bit 2 set zeroes the cycle counter. Both bits read back as 0, and a zeroed counter reports no wrap in that cycle.
- R8: A write to a counter or to a cycle-counter half loads the written value, and counting continues from it. In a cycle where a write and an increment coincide, the written value wins.
- R9: Addresses 6 and 7 return bits [31:0] and [63:32] of the event availability parameter. Writes to them are ignored.
- R10: Bits of the enable and interrupt-enable bitmaps that belong to no counter cannot be set and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effects only on overflow status) |
| regAddr | input | ADDR_W | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| eventBus | input | EVT_BUS_W | Event input lines, one pulse counted per high cycle |
| irqOut | output | 1 | Overflow interrupt |

## Verification
A counter that misses or doubles a tick stays hidden until software reads it or until it wraps. For that reason the bench reads every counter often and drives counters close to 0xFFFFFFFF, so that a wrong increment quickly shows up as a wrong or late overflow bit. The irq line is compared against the reference model on every clock, so an overflow or mask bit that is wrong is seen in the cycle it goes wrong. A clearing read that races with a wrap is driven on purpose, because a wrong priority there loses an overflow without any other sign.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int PM_ADDR_CTRL   = 0;
  localparam int PM_ADDR_EN     = 1;
  localparam int PM_ADDR_IE     = 2;
  localparam int PM_ADDR_OVF    = 3;
  localparam int PM_ADDR_CYC_LO = 4;
  localparam int PM_ADDR_CYC_HI = 5;
  localparam int PM_ADDR_AV_LO  = 6;
  localparam int PM_ADDR_AV_HI  = 7;
  localparam int PM_CNT_BASE    = 32;
  localparam int PM_SEL_BASE    = 64;
  localparam int PM_CYC_BIT     = 31;

  // Write strobes from the control block to the counter datapath
  typedef struct packed {
    logic        evtClr;
    logic        cycClr;
    logic        cntWr;
    logic [4:0]  cntIdx;
    logic        cycWrLo;
    logic        cycWrHi;
    logic [31:0] wrData;
  } pmonStrobe_t;
endpackage

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int EVT_BUS_W = 6,
  parameter int ADDR_W = 7,
  parameter logic [7:0] ID_CODE = 8'h5A,
  parameter logic [7:0] IMPL_CODE = 8'h41,
  parameter logic [63:0] AVAIL_MAP = 64'h0000_00F0_3E00_0801
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic                   regRdEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  logic [EVT_BUS_W-1:0]   eventBus,
  input  logic [NUM_CNT*32-1:0]  cntFlat,
  input  logic [63:0]            cycVal,
  input  logic [31:0]            wrapVec,
  output pmonStrobe_t            strobe,
  output logic [NUM_CNT-1:0]     evtTick,
  output logic                   cycTick,
  output logic [31:0]            ovfStatus,
  output logic                   globalEn,
  output logic                   irqOut
);
  localparam int SEL_W = (EVT_BUS_W > 1) ? $clog2(EVT_BUS_W) : 1;
  localparam int BUS_PAD = 1 << SEL_W;
  localparam logic [31:0] VALID_MASK = (32'(1) << PM_CYC_BIT) | ((32'(1) << NUM_CNT) - 32'(1));

  logic [31:0] enMask, ieMask;
  logic [SEL_W-1:0] selReg [NUM_CNT];
  logic [BUS_PAD-1:0] busPad;
  logic wrCtrl, rdOvf, inCntRange;
  logic [ADDR_W-1:0] cntOff;

  assign busPad = BUS_PAD'(eventBus);
  assign wrCtrl = regWrEn && (regAddr == ADDR_W'(PM_ADDR_CTRL));
  assign rdOvf  = regRdEn && (regAddr == ADDR_W'(PM_ADDR_OVF));
  assign cntOff = regAddr - ADDR_W'(PM_CNT_BASE);
  assign inCntRange = (regAddr >= ADDR_W'(PM_CNT_BASE)) &&
                      (regAddr < ADDR_W'(PM_CNT_BASE + NUM_CNT));

  always_comb begin
    strobe.evtClr  = wrCtrl && regWrData[1];
    strobe.cycClr  = wrCtrl && regWrData[2];
    strobe.cntWr   = regWrEn && inCntRange;
    strobe.cntIdx  = 5'(cntOff);
    strobe.cycWrLo = regWrEn && (regAddr == ADDR_W'(PM_ADDR_CYC_LO));
    strobe.cycWrHi = regWrEn && (regAddr == ADDR_W'(PM_ADDR_CYC_HI));
    strobe.wrData  = regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      enMask    <= '0;
      ieMask    <= '0;
      ovfStatus <= '0;
    end else begin
      if (wrCtrl) globalEn <= regWrData[0];
      if (regWrEn && regAddr == ADDR_W'(PM_ADDR_EN)) enMask <= regWrData & VALID_MASK;
      if (regWrEn && regAddr == ADDR_W'(PM_ADDR_IE)) ieMask <= regWrData & VALID_MASK;
      // a wrap landing in the clearing cycle survives the clear
      ovfStatus <= (rdOvf ? 32'd0 : ovfStatus) | wrapVec;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CNT; g++) begin : gSel
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) selReg[g] <= '0;
        else if (regWrEn && regAddr == ADDR_W'(PM_SEL_BASE + g)) selReg[g] <= regWrData[SEL_W-1:0];
      end
      assign evtTick[g] = globalEn && enMask[g] && (32'(selReg[g]) < EVT_BUS_W) && busPad[selReg[g]];
    end
  endgenerate

  assign cycTick = globalEn && enMask[PM_CYC_BIT];
  assign irqOut  = |(ovfStatus & ieMask);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(PM_ADDR_CTRL):   regRdData = {IMPL_CODE, ID_CODE, 5'(NUM_CNT), 10'd0, globalEn};
      ADDR_W'(PM_ADDR_EN):     regRdData = enMask;
      ADDR_W'(PM_ADDR_IE):     regRdData = ieMask;
      ADDR_W'(PM_ADDR_OVF):    regRdData = ovfStatus;
      ADDR_W'(PM_ADDR_CYC_LO): regRdData = cycVal[31:0];
      ADDR_W'(PM_ADDR_CYC_HI): regRdData = cycVal[63:32];
      ADDR_W'(PM_ADDR_AV_LO):  regRdData = AVAIL_MAP[31:0];
      ADDR_W'(PM_ADDR_AV_HI):  regRdData = AVAIL_MAP[63:32];
      default: begin
        for (int i = 0; i < NUM_CNT; i++) begin
          if (regAddr == ADDR_W'(PM_CNT_BASE + i)) regRdData = cntFlat[i*32 +: 32];
          if (regAddr == ADDR_W'(PM_SEL_BASE + i)) regRdData = 32'(selReg[i]);
        end
      end
    endcase
  end
endmodule

// File: rtl/pmon_datapath.sv
module pmon_datapath
  import pmon_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pmonStrobe_t           strobe,
  input  logic [NUM_CNT-1:0]    evtTick,
  input  logic                  cycTick,
  output logic [NUM_CNT*32-1:0] cntFlat,
  output logic [63:0]           cycVal,
  output logic [31:0]           wrapVec
);
  genvar g;
  generate
    for (g = 0; g < NUM_CNT; g++) begin : gEvt
      logic [31:0] cnt;
      logic hit;
      assign hit = strobe.cntWr && (strobe.cntIdx == 5'(g));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              cnt <= '0;
        else if (strobe.evtClr) cnt <= '0;
        else if (hit)           cnt <= strobe.wrData;
        else if (evtTick[g])    cnt <= cnt + 32'd1;
      end
      assign cntFlat[g*32 +: 32] = cnt;
      assign wrapVec[g] = evtTick[g] && !strobe.evtClr && !hit && (cnt == 32'hFFFF_FFFF);
    end
    for (g = NUM_CNT; g < PM_CYC_BIT; g++) begin : gNone
      assign wrapVec[g] = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cycVal <= '0;
    else if (strobe.cycClr)  cycVal <= '0;
    else if (strobe.cycWrLo) cycVal[31:0] <= strobe.wrData;
    else if (strobe.cycWrHi) cycVal[63:32] <= strobe.wrData;
    else if (cycTick)        cycVal <= cycVal + 64'd1;
  end

  assign wrapVec[PM_CYC_BIT] = cycTick && !strobe.cycClr && !strobe.cycWrLo &&
                               !strobe.cycWrHi && (cycVal == 64'hFFFF_FFFF_FFFF_FFFF);
endmodule

// File: rtl/pmon_top.sv
module pmon_top
  import pmon_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int EVT_BUS_W = 6,
  parameter int ADDR_W = 7,
  parameter logic [7:0] ID_CODE = 8'h5A,
  parameter logic [7:0] IMPL_CODE = 8'h41,
  parameter logic [63:0] AVAIL_MAP = 64'h0000_00F0_3E00_0801
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regRdEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [EVT_BUS_W-1:0] eventBus,
  output logic                 irqOut
);
  pmonStrobe_t strobe;
  logic [NUM_CNT-1:0] evtTick;
  logic cycTick;
  logic [NUM_CNT*32-1:0] cntFlat;
  logic [63:0] cycVal;
  logic [31:0] wrapVec;
  logic [31:0] ovfStatus;
  logic globalEn;

  pmon_ctrl #(
    .NUM_CNT(NUM_CNT), .EVT_BUS_W(EVT_BUS_W), .ADDR_W(ADDR_W),
    .ID_CODE(ID_CODE), .IMPL_CODE(IMPL_CODE), .AVAIL_MAP(AVAIL_MAP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .eventBus(eventBus), .cntFlat(cntFlat), .cycVal(cycVal), .wrapVec(wrapVec),
    .strobe(strobe), .evtTick(evtTick), .cycTick(cycTick),
    .ovfStatus(ovfStatus), .globalEn(globalEn), .irqOut(irqOut)
  );

  pmon_datapath #(.NUM_CNT(NUM_CNT)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evtTick(evtTick), .cycTick(cycTick),
    .cntFlat(cntFlat), .cycVal(cycVal), .wrapVec(wrapVec)
  );
endmodule

// File: rtl/pmon_checker.sv
module pmon_checker #(
  parameter int ADDR_W = 7,
  parameter int NUM_CNT = 4,
  parameter logic [7:0] ID_CODE = 8'h5A,
  parameter logic [7:0] IMPL_CODE = 8'h41
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [31:0]       regRdData,
  input logic              irqOut,
  input logic [31:0]       ovfStatus,
  input logic [31:0]       wrapVec,
  input logic              globalEn,
  input logic [63:0]       cycVal
);
  AST_CTRL_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == '0) |-> (regRdData[31:1] == {IMPL_CODE, ID_CODE, 5'(NUM_CNT), 10'd0})); // R1
  AST_CTRL_SELFCLR: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == '0) |-> (regRdData[2:1] == 2'b00)); // R7
  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!regWrEn && !globalEn) |=> $stable(cycVal)); // R2
  AST_WRAP_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    (wrapVec != '0) |=> ((ovfStatus & $past(wrapVec)) == $past(wrapVec))); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(3)) |=> ((ovfStatus & $past(regRdData) & ~$past(wrapVec)) == '0)); // R5
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ovfStatus != '0)); // R6
  AST_CYC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(4)) |=> (cycVal[31:0] == $past(regWrData))); // R8
endmodule

bind pmon_top pmon_checker #(
  .ADDR_W(ADDR_W), .NUM_CNT(NUM_CNT), .ID_CODE(ID_CODE), .IMPL_CODE(IMPL_CODE)
) uChk (.*);

// File: tb/pmon_top_test.sv
module pmon_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM = 4;
  localparam int EVT_W = 6;
  localparam int SEL_W = 3;
  localparam logic [7:0] ID = 8'h5A;
  localparam logic [7:0] IMPL = 8'h41;
  localparam logic [63:0] AVAIL = 64'h0000_00F0_3E00_0801;
  localparam logic [31:0] VALID = 32'h8000_000F;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 0, regRdEn = 0;
  logic [6:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [EVT_W-1:0] eventBus = '0;
  logic irqOut;
  int total = 0, bad = 0;

  // reference state
  logic [31:0] mCnt [NUM];
  int          mSel [NUM];
  logic [63:0] mCyc;
  logic [31:0] mEn, mIe, mOvf;
  logic        mGe;

  pmon_top #(.NUM_CNT(NUM), .EVT_BUS_W(EVT_W), .ADDR_W(7), .ID_CODE(ID),
             .IMPL_CODE(IMPL), .AVAIL_MAP(AVAIL)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .eventBus(eventBus), .irqOut(irqOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(int a);
    if (a == 0) return {IMPL, ID, 5'(NUM), 10'd0, mGe};
    if (a == 1) return mEn;
    if (a == 2) return mIe;
    if (a == 3) return mOvf;
    if (a == 4) return mCyc[31:0];
    if (a == 5) return mCyc[63:32];
    if (a == 6) return AVAIL[31:0];
    if (a == 7) return AVAIL[63:32];
    if (a >= 32 && a < 32 + NUM) return mCnt[a-32];
    if (a >= 64 && a < 64 + NUM) return 32'(mSel[a-64]);
    return 32'd0;
  endfunction

  function automatic string tagFor(int a);
    if (a == 0) return "R1";
    if (a == 1 || a == 2) return "R10";
    if (a == 3) return "R5";
    if (a == 4 || a == 5) return "R4";
    if (a == 6 || a == 7) return "R9";
    return "R2";
  endfunction

  task automatic modelStep(bit w, bit r, int a, logic [31:0] d, logic [EVT_W-1:0] e);
    logic [31:0] wrap = '0;
    bit clrE = w && a == 0 && d[1];
    bit clrC = w && a == 0 && d[2];
    for (int i = 0; i < NUM; i++) begin
      bit tk = mGe && mEn[i] && (mSel[i] < EVT_W) && e[mSel[i]];
      if (clrE) mCnt[i] = 0;
      else if (w && a == 32 + i) mCnt[i] = d;
      else if (tk) begin
        if (mCnt[i] == 32'hFFFF_FFFF) wrap[i] = 1'b1;
        mCnt[i] = mCnt[i] + 1;
      end
    end
    if (clrC) mCyc = 0;
    else if (w && a == 4) mCyc = {mCyc[63:32], d};
    else if (w && a == 5) mCyc = {d, mCyc[31:0]};
    else if (mGe && mEn[31]) begin
      if (mCyc == 64'hFFFF_FFFF_FFFF_FFFF) wrap[31] = 1'b1;
      mCyc = mCyc + 1;
    end
    if (r && a == 3) mOvf = 0;
    mOvf = mOvf | wrap;
    if (w && a == 0) mGe = d[0];
    if (w && a == 1) mEn = d & VALID;
    if (w && a == 2) mIe = d & VALID;
    for (int i = 0; i < NUM; i++)
      if (w && a == 64 + i) mSel[i] = int'(d[SEL_W-1:0]);
  endtask

  task automatic step(bit w, bit r, int a, logic [31:0] d, logic [EVT_W-1:0] e, string tag);
    @(negedge clk);
    regWrEn = w; regRdEn = r; regAddr = 7'(a); regWrData = d; eventBus = e;
    #1;
    if (r) check(tag, regRdData, modelRead(a));
    check("R6", 32'(irqOut), 32'(|(mOvf & mIe)));
    @(posedge clk);
    modelStep(w, r, a, d, e);
  endtask

  task automatic wr(int a, logic [31:0] d); step(1, 0, a, d, '0, "W"); endtask
  task automatic rd(int a, string tag); step(0, 1, a, '0, '0, tag); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NUM; i++) begin mCnt[i] = 0; mSel[i] = 0; end
    mCyc = 0; mEn = 0; mIe = 0; mOvf = 0; mGe = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    rd(0, "R1"); rd(1, "R10"); rd(3, "R5"); rd(4, "R4"); rd(32, "R2");
    rd(6, "R9"); rd(7, "R9");
    wr(6, 32'hFFFF_FFFF); wr(7, 32'h1234_5678); rd(6, "R9"); rd(7, "R9");
    // bitmaps only hold real counters
    wr(1, 32'hFFFF_FFFF); rd(1, "R10");
    wr(2, 32'hFFFF_FFFF); rd(2, "R10");
    // selects, including one past the bus width
    wr(64, 2); wr(65, 5); wr(66, 7); wr(67, 0); rd(66, "R2"); rd(65, "R2");
    // no counting while globally disabled
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, '1, "R2");
    rd(32, "R2"); rd(4, "R2");
    // enabled counting with varied patterns
    wr(0, 1);
    for (int k = 0; k < 20; k++) step(0, 0, 0, 0, EVT_W'(k * 37), "R2");
    for (int i = 0; i < 4; i++) rd(32 + i, "R2");
    rd(4, "R4"); rd(0, "R1");
    // per-counter enable off for counter 1
    wr(1, 32'h8000_000D);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, '1, "R2");
    rd(33, "R2"); rd(32, "R2");
    // write coinciding with increment, then wrap
    step(1, 0, 32, 32'hFFFF_FFFE, '1, "R8");
    rd(32, "R8");
    step(0, 0, 0, 0, 6'h04, "R3"); step(0, 0, 0, 0, 6'h04, "R3");
    rd(32, "R3"); rd(3, "R3"); rd(3, "R5");
    // wrap in the same cycle as the clearing read
    wr(32, 32'hFFFF_FFFF);
    step(0, 1, 3, 0, 6'h04, "R5");
    rd(3, "R5"); rd(3, "R5");
    // interrupt masking
    wr(2, 0); wr(32, 32'hFFFF_FFFF); step(0, 0, 0, 0, 6'h04, "R6");
    rd(1, "R6"); wr(2, 1); rd(1, "R6"); rd(3, "R5");
    // cycle counter halves and 64-bit wrap
    wr(5, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFC);
    rd(5, "R8");
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, '0, "R4");
    rd(4, "R4"); rd(5, "R4"); rd(3, "R4");
    // reset controls
    wr(0, 32'h0000_0007); rd(0, "R7"); rd(32, "R7"); rd(4, "R7");
    wr(0, 32'h0000_0005); rd(5, "R7");
    // randomised mix
    for (int k = 0; k < 2000; k++) begin
      int pick = int'($urandom_range(0, 15));
      int a;
      logic [31:0] d = $urandom;
      logic [EVT_W-1:0] e = EVT_W'($urandom);
      if (pick < 6) begin
        a = int'($urandom_range(0, 11));
        a = (a < 8) ? a : 32 + (a - 8);
        step(0, 1, a, 0, e, tagFor(a));
      end else if (pick < 9) begin
        a = 32 + int'($urandom_range(0, NUM - 1));
        step(1, 0, a, 32'hFFFF_FFF0 | (d & 32'hF), e, "R8");
      end else if (pick == 9) begin
        a = int'($urandom_range(0, 2));
        if (a == 0) d = 32'h1 | (($urandom_range(0, 7) == 0) ? (d & 32'h6) : 32'h0);
        step(1, 0, a, d, e, "R7");
      end else if (pick == 10) begin
        step(1, 0, 64 + int'($urandom_range(0, NUM - 1)), d, e, "R2");
      end else if (pick == 11) begin
        step(1, 0, 4, 32'hFFFF_FFF0 | (d & 32'hF), e, "R8");
      end else begin
        step(0, 0, 0, 0, e, "R2");
      end
    end
    for (int a = 0; a < 8; a++) rd(a, tagFor(a));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule